// File: doc/BRIEF.md
# Three-Wire Register Bus Master

This block turns single-register requests from a host into transactions on a three-wire control bus. The bus has a serial clock, a data line that the master either drives or listens to, and a read/write select line. Each host request carries an address, write data and a direction flag, and uses a valid/ready handshake. A read also returns one byte on a response strobe.

The device behind the bus keeps its registers in two banks. Host addresses from `BANK_SPLIT` upward go to the upper bank, and the rest go to the lower bank. The master remembers which bank it selected last. It inserts a separate bank-select write only when a request targets the other bank, or when the remembered value has been invalidated. This saves a full write cycle on every access that stays in the current bank.

A power-enable input gates the whole bus. While it is low, the master accepts requests but leaves the bus untouched, and every read answers zero.

Top module: `twb_master`

## Requirements
- R1: Each byte is sent as 8 bit periods, least significant bit first. In each period the clock falls and the data line takes the new bit. The clock then stays low for exactly `DELAY_CYCLES` system clocks, rises, and stays high for at least `DELAY_CYCLES` system clocks. The driven data changes only while the clock is low.
- R2: A write cycle opens by raising the read/write select line and enabling the data driver together. At least `DELAY_CYCLES` system clocks pass before the first clock fall. The driver is never enabled while the select line is low.
- R3: A write cycle closes by releasing the data driver and lowering the select line in the same cycle. Neither a clock fall nor a new cycle follows within `DELAY_CYCLES` system clocks. When idle, the bus clock rests high and the driver is off.
- R4: A host address at or above `BANK_SPLIT` targets bank number 2, at on-bus address `addr - BANK_SPLIT`. A lower address targets bank number 1, at on-bus address `addr`.
- R5: When the target bank differs from the remembered bank, the master first runs a complete write cycle of two bytes: the bank number (1 or 2), then `BANK_SEL_REG`. Only then does it run the access. When the banks match, no such cycle occurs.
- R6: A register write is one write cycle of two bytes: the data byte first, then the on-bus address byte.
- R7: A register read is a write cycle that carries only the on-bus address byte. It is followed by 8 clock periods with the driver off and the select line low. In each period the input is sampled just before the rising edge, least significant bit first. The byte is returned on `rsp_rdata` with a one-cycle `rsp_valid`.
- R8: After reset the remembered bank is invalid, so the first access always performs a bank switch.
- R9: `req_ready` drops in the cycle after a request is accepted with power enabled. It returns high only when the final close delay (for a write) or the read phase has completed.
- R10: A request accepted while `pwr_en` is low causes no bus activity and keeps `req_ready` high. A read answers with `rsp_valid` and `rsp_rdata` = 0 in the following cycle. A write leaves the device register unchanged.
- R11: While `pwr_en` is low the remembered bank is invalidated, so the first access after power returns performs a bank switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Bus power enable; requests are ignored while low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Master can accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | ADDR_W | Host register address across both banks |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe carrying read data |
| rsp_rdata | output | 8 | Byte read from the device |
| bus_clk | output | 1 | Serial bus clock, idles high |
| bus_rw | output | 1 | Read/write select, high during write cycles |
| bus_data_o | output | 1 | Serial data to the device |
| bus_data_oe | output | 1 | Data driver enable |
| bus_data_i | input | 1 | Serial data from the device |

## Verification
The bench builds the master with `ADDR_W` = 5 and `BANK_SPLIT` = 16, so both banks of 16 registers are covered in full by an ascending write sweep and by a read sweep in a scrambled order that switches banks often. `DELAY_CYCLES` = 2 keeps every bit period short enough for hundreds of frames to run quickly, while still allowing exact low-phase lengths and open/close gaps to be measured. `BANK_SEL_REG` = 0x0F places the bank-select register inside each bank, so the sweeps skip that slot and every other register is written and read back through a model of the device.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_SHIFT,
        ST_CLOSE,
        ST_READ
    } twb_state_e;

    localparam logic [1:0] BANK_NONE = 2'd0;
    localparam logic [1:0] BANK_LO   = 2'd1;
    localparam logic [1:0] BANK_HI   = 2'd2;

endpackage

// File: rtl/twb_bank_map.sv
module twb_bank_map
    import twb_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int BANK_SPLIT = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [1:0]        bank_o,
    output logic [7:0]        local_o
);

    always_comb begin
        if (int'(addr_i) >= BANK_SPLIT) begin
            bank_o  = BANK_HI;
            local_o = 8'(int'(addr_i) - BANK_SPLIT);
        end else begin
            bank_o  = BANK_LO;
            local_o = 8'(int'(addr_i));
        end
    end

endmodule

// File: rtl/twb_shifter.sv
module twb_shifter #(
    parameter int DELAY_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_i,
    input  logic       sdi_i,
    output logic       sclk_o,
    output logic       sdo_o,
    output logic [7:0] rx_o,
    output logic       done_o
);

    localparam int CNT_W = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic             hi;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bits;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             sclk;
        logic             done;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.hi   = 1'b0;
                d.cnt  = '0;
                d.bits = '0;
                d.tx   = byte_i;
                d.sclk = 1'b0;
            end
        end else if (!q.hi) begin
            if (q.cnt == CNT_LAST) begin
                d.rx   = {sdi_i, q.rx[7:1]};
                d.hi   = 1'b1;
                d.cnt  = '0;
                d.sclk = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                if (q.bits == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bits = q.bits + 1'b1;
                    d.tx   = {1'b0, q.tx[7:1]};
                    d.hi   = 1'b0;
                    d.sclk = 1'b0;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign sdo_o  = q.tx[0];
    assign rx_o   = q.rx;
    assign done_o = q.done;

endmodule

// File: rtl/twb_master.sv
module twb_master
    import twb_pkg::*;
#(
    parameter int         ADDR_W       = 5,
    parameter int         BANK_SPLIT   = 16,
    parameter int         DELAY_CYCLES = 2,
    parameter logic [7:0] BANK_SEL_REG = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    output logic              bus_clk,
    output logic              bus_rw,
    output logic              bus_data_o,
    output logic              bus_data_oe,
    input  logic              bus_data_i
);

    localparam int CNT_W = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

    typedef struct packed {
        twb_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             bank_cyc;
        logic             byte_idx;
        logic             is_wr;
        logic [7:0]       laddr;
        logic [7:0]       wdata;
        logic [1:0]       nbank;
        logic [1:0]       bank;
        logic             rw;
        logic             oe;
        logic             start;
        logic [7:0]       sbyte;
        logic             rdy;
        logic             rsp_v;
        logic [7:0]       rdata;
    } ctl_t;

    ctl_t d, q;

    logic [1:0] map_bank;
    logic [7:0] map_local;
    logic       sh_done;
    logic [7:0] sh_rx;

    twb_bank_map #(
        .ADDR_W     (ADDR_W),
        .BANK_SPLIT (BANK_SPLIT)
    ) i_map (
        .addr_i  (req_addr),
        .bank_o  (map_bank),
        .local_o (map_local)
    );

    twb_shifter #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) i_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (q.start),
        .byte_i  (q.sbyte),
        .sdi_i   (bus_data_i),
        .sclk_o  (bus_clk),
        .sdo_o   (bus_data_o),
        .rx_o    (sh_rx),
        .done_o  (sh_done)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.rsp_v = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!pwr_en) begin
                        if (!req_write) begin
                            d.rsp_v = 1'b1;
                            d.rdata = 8'h00;
                        end
                    end else begin
                        d.rdy      = 1'b0;
                        d.is_wr    = req_write;
                        d.laddr    = map_local;
                        d.wdata    = req_wdata;
                        d.nbank    = map_bank;
                        d.bank_cyc = (map_bank != q.bank);
                        d.st       = ST_OPEN;
                        d.rw       = 1'b1;
                        d.oe       = 1'b1;
                        d.cnt      = '0;
                    end
                end
            end
            ST_OPEN: begin
                if (q.cnt == CNT_LAST) begin
                    d.st       = ST_SHIFT;
                    d.start    = 1'b1;
                    d.byte_idx = 1'b0;
                    if (q.bank_cyc)   d.sbyte = {6'b0, q.nbank};
                    else if (q.is_wr) d.sbyte = q.wdata;
                    else              d.sbyte = q.laddr;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    if (!q.byte_idx && (q.bank_cyc || q.is_wr)) begin
                        d.start    = 1'b1;
                        d.byte_idx = 1'b1;
                        d.sbyte    = q.bank_cyc ? BANK_SEL_REG : q.laddr;
                    end else begin
                        d.st  = ST_CLOSE;
                        d.rw  = 1'b0;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end
                end
            end
            ST_CLOSE: begin
                if (q.cnt == CNT_LAST) begin
                    d.cnt = '0;
                    if (q.bank_cyc) begin
                        d.bank     = q.nbank;
                        d.bank_cyc = 1'b0;
                        d.st       = ST_OPEN;
                        d.rw       = 1'b1;
                        d.oe       = 1'b1;
                    end else if (!q.is_wr) begin
                        d.st    = ST_READ;
                        d.start = 1'b1;
                    end else begin
                        d.st  = ST_IDLE;
                        d.rdy = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_READ: begin
                if (sh_done) begin
                    d.rdata = sh_rx;
                    d.rsp_v = 1'b1;
                    d.st    = ST_IDLE;
                    d.rdy   = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!pwr_en) d.bank = BANK_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.bank <= BANK_NONE;
            q.rdy  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = q.rdy;
    assign rsp_valid   = q.rsp_v;
    assign rsp_rdata   = q.rdata;
    assign bus_rw      = q.rw;
    assign bus_data_oe = q.oe;

endmodule

// File: rtl/twb_master_chk.sv
module twb_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic       rsp_valid,
    input logic [7:0] rsp_rdata,
    input logic       bus_clk,
    input logic       bus_rw,
    input logic       bus_data_o,
    input logic       bus_data_oe
);

    AST_DATA_HELD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clk |-> $stable(bus_data_o)); // R1

    AST_DRIVER_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> bus_rw); // R2

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_clk && !bus_data_oe && !bus_rw)); // R3

    AST_RSP_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R7

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && pwr_en) |=> !req_ready); // R9

    AST_OFF_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pwr_en) |=> (req_ready && !bus_rw)); // R10

    AST_OFF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !pwr_en && !req_write) |=>
            (rsp_valid && rsp_rdata == 8'h00)); // R10

endmodule

bind twb_master twb_master_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_en      (pwr_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .bus_clk     (bus_clk),
    .bus_rw      (bus_rw),
    .bus_data_o  (bus_data_o),
    .bus_data_oe (bus_data_oe)
);

// File: tb/test_twb_master.sv
`timescale 1ns/1ps
module test_twb_master;

    localparam int         AW    = 5;
    localparam int         SPLIT = 16;
    localparam int         DLY   = 2;
    localparam logic [7:0] BSEL  = 8'h0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic bus_data_i = 1'b0;
    logic req_ready, rsp_valid, bus_clk, bus_rw, bus_data_o, bus_data_oe;
    logic [7:0] rsp_rdata;

    always #2.5 clk = ~clk;

    twb_master #(
        .ADDR_W       (AW),
        .BANK_SPLIT   (SPLIT),
        .DELAY_CYCLES (DLY),
        .BANK_SEL_REG (BSEL)
    ) i_twb_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_en      (pwr_en),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .bus_clk     (bus_clk),
        .bus_rw      (bus_rw),
        .bus_data_o  (bus_data_o),
        .bus_data_oe (bus_data_oe),
        .bus_data_i  (bus_data_i)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // device model, sampled away from the active edge
    logic [7:0] dev_mem [0:3][0:15];
    logic [1:0] dev_bank = 2'd0;
    logic [7:0] cur = '0;
    logic [7:0] bytes0 = '0, bytes1 = '0;
    int nbits = 0, nbytes = 0;
    int bank_cnt = 0, wr_cnt = 0, rd_cnt = 0, cyc_cnt = 0, odd_cnt = 0;
    logic [7:0] last_d = '0, last_a = '0, rd_ptr = '0;
    bit rd_arm = 0, first_fall = 0, after_close = 0;
    int rd_bits = 0;
    int ncyc = 0, t_rw = -100, t_close = -100, t_fall = 0;
    int low_bad = 0, open_bad = 0, close_bad = 0;
    logic p_clk = 1'b1, p_rw = 1'b0;

    initial begin
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 16; r++) dev_mem[b][r] = 8'h00;
    end

    always @(negedge clk) begin
        ncyc++;
        if (rst_n) begin
            if (bus_rw && !p_rw) begin
                if (ncyc - t_close < DLY) close_bad++;
                t_rw = ncyc; nbits = 0; nbytes = 0; rd_arm = 0;
                first_fall = 1; after_close = 0;
            end
            if (!bus_clk && p_clk) begin
                t_fall = ncyc;
                if (bus_rw && first_fall) begin
                    if (ncyc - t_rw < DLY) open_bad++;
                    first_fall = 0;
                end
                if (!bus_rw && after_close) begin
                    if (ncyc - t_close < DLY) close_bad++;
                    after_close = 0;
                end
                if (rd_arm && !bus_rw && !bus_data_oe) begin
                    bus_data_i = dev_mem[dev_bank][rd_ptr[3:0]][rd_bits];
                    rd_bits++;
                    if (rd_bits == 8) rd_arm = 0;
                end
            end
            if (bus_clk && !p_clk) begin
                if (ncyc - t_fall != DLY) low_bad++;
                if (bus_rw && bus_data_oe) begin
                    cur = {bus_data_o, cur[7:1]};
                    nbits++;
                    if (nbits == 8) begin
                        if (nbytes == 0) bytes0 = cur; else bytes1 = cur;
                        nbytes++;
                        nbits = 0;
                    end
                end
            end
            if (!bus_rw && p_rw) begin
                t_close = ncyc; after_close = 1; cyc_cnt++;
                if (nbytes == 2 && bytes1 == BSEL) begin
                    dev_bank = bytes0[1:0]; bank_cnt++;
                end else if (nbytes == 2 && bytes1 < 16) begin
                    dev_mem[dev_bank][bytes1[3:0]] = bytes0;
                    last_d = bytes0; last_a = bytes1; wr_cnt++;
                end else if (nbytes == 1 && bytes0 < 16) begin
                    rd_ptr = bytes0; rd_arm = 1; rd_bits = 0; rd_cnt++;
                end else begin
                    odd_cnt++;
                end
            end
        end
        p_clk = bus_clk;
        p_rw  = bus_rw;
    end

    // bench-side expectation
    logic [7:0] exp_mem [0:31];
    int exp_bank = 0;

    task automatic do_req(input bit wr, input int a, input logic [7:0] dat, output logic [7:0] rd);
        int b0, c0, w0, r0, tb, lo;
        bit sw, got;
        b0 = bank_cnt; c0 = cyc_cnt; w0 = wr_cnt; r0 = rd_cnt;
        tb = (a >= SPLIT) ? 2 : 1;
        lo = (a >= SPLIT) ? a - SPLIT : a;
        rd = 8'hxx; got = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = dat;
        @(negedge clk);
        req_valid = 1'b0;
        if (pwr_en) chk(!req_ready, "R9 ready low after accept", req_ready, 0);
        do begin
            if (rsp_valid) begin rd = rsp_rdata; got = 1; end
            if (!req_ready) @(negedge clk);
        end while (!req_ready);
        if (rsp_valid) begin rd = rsp_rdata; got = 1; end
        if (!pwr_en) begin
            chk(cyc_cnt == c0, "R10 no bus cycles while off", cyc_cnt - c0, 0);
            if (!wr) chk(got && rd == 8'h00, "R10 read returns zero while off", rd, 0);
            exp_bank = 0;
        end else begin
            sw = (tb != exp_bank);
            exp_bank = tb;
            chk(bank_cnt - b0 == int'(sw), "R5 R8 R11 bank switch count", bank_cnt - b0, int'(sw));
            chk(int'(dev_bank) == tb, "R4 bank number sent", dev_bank, tb);
            if (wr) begin
                exp_mem[a] = dat;
                chk(wr_cnt - w0 == 1 && last_d == dat, "R6 data byte first", last_d, dat);
                chk(int'(last_a) == lo, "R4 R6 on-bus address second", last_a, lo);
            end else begin
                chk(rd_cnt - r0 == 1, "R7 address-only frame", rd_cnt - r0, 1);
                chk(got && rd == exp_mem[a], "R7 read data", rd, exp_mem[a]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R9 reset ready", req_ready, 1);
        chk(bus_clk == 1'b1 && bus_rw == 1'b0 && bus_data_oe == 1'b0, "R3 reset bus idle",
            {bus_clk, bus_rw, bus_data_oe}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: first access after reset switches bank; ascending write sweep
        for (int a = 0; a < 32; a++) begin
            if ((a % 16) == int'(BSEL)) continue;
            do_req(1'b1, a, 8'((a * 37 + 11) & 8'hFF), r);
        end
        // scrambled read sweep, frequent bank changes
        for (int i = 0; i < 32; i++) begin
            int a;
            a = (i * 13) % 32;
            if ((a % 16) == int'(BSEL)) continue;
            do_req(1'b0, a, 8'h00, r);
        end
        // back-to-back alternation with new data
        for (int i = 0; i < 8; i++) begin
            int a;
            a = (i % 2 == 0) ? i : i + SPLIT;
            do_req(1'b1, a, 8'(8'hA5 ^ i), r);
            do_req(1'b0, a, 8'h00, r);
        end

        // R10 / R11: power off, ignored requests, then re-enable
        do_req(1'b0, 2, 8'h00, r);
        pwr_en = 1'b0;
        @(negedge clk);
        do_req(1'b1, 3, 8'hEE, r);
        do_req(1'b0, 3, 8'h00, r);
        chk(dev_mem[1][3] == exp_mem[3], "R10 write ignored while off", dev_mem[1][3], exp_mem[3]);
        pwr_en = 1'b1;
        @(negedge clk);
        do_req(1'b0, 3, 8'h00, r);
        do_req(1'b0, 4, 8'h00, r);

        // R8 again: reset invalidates the bank memory
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_bank = 0;
        @(negedge clk);
        do_req(1'b0, 5, 8'h00, r);

        chk(low_bad == 0, "R1 clock low phase length", low_bad, 0);
        chk(open_bad == 0, "R2 open delay before clocking", open_bad, 0);
        chk(close_bad == 0, "R3 close delay after cycle", close_bad, 0);
        chk(odd_cnt == 0, "R5 R6 R7 frame shapes", odd_cnt, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule